// File: doc/BRIEF.md
# Protected Memory Command Executor

This block sits behind a serial programming front end and carries out the commands the front end has already decoded. It owns two register-modelled memory areas and one 10-bit program counter that addresses both of them. The encoder area holds 64 bytes inside a 256-entry byte space. The configuration area holds sixteen 12-bit words inside a 1024-entry space. Its upper eight words are views of a single shared configuration word. A write latch takes load data. A self-timed program cycle then commits that data to whichever area the load was aimed at. The cycle either replaces the stored value, or ANDs the new value into it when the erase step is left out. An armed bulk erase can take the place of the word write.

Bit 6 of the shared configuration word guards the encoder area. While the bit is 0, encoder reads return zero and encoder writes, including bulk erases, are dropped. The configuration word only accepts a program cycle that changes this bit. When a cycle changes the bit from 0 to 1, every encoder byte is set to FFh, so the encoder contents are never exposed. The front end presents one command per strobe, with its data word on the same strobe. It gets read results one clock later. It watches `busy` to pace program cycles.

The control path is a three-state machine. ST_IDLE accepts a program command and moves to ST_BUSY. ST_BUSY waits for the cycle timer to expire and moves to ST_COMMIT. ST_COMMIT applies the write or erase in one clock and returns to ST_IDLE.

Top module: `pce_cmd_exec`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and the program counter is 3FFh. A `mode_enter` pulse sets the counter to 3FFh again and discards any pending load or bulk erase. A configuration read at 3FFh returns 000h.
- R2: Load-config (code 000000) sets the program counter to 3FFh. Increment (code 000110) adds one modulo 1024, so the first increment after that load points at 000h.
- R3: Configuration addresses 008h–00Fh all read the one shared word, which resets to `CFG_INIT` (0A1h by default). Addresses 010h–3FFh read 000h. Addresses 000h–007h are eight separate writable words that reset to 000h.
- R4: Bit 6 of the shared word is an active-low protect flag. While it is 0, encoder reads return 000h. Configuration reads work whatever the value of the flag.
- R5: A program cycle aimed at 008h–00Fh changes the shared word only if bit 6 of the latched data differs from the stored bit 6.
- R6: A program cycle with erase (code 001000) that moves bit 6 of the shared word from 0 to 1 sets every encoder byte to FFh.
- R7: The encoder area is addressed by PC[7:0] only, so PC 100h reaches byte 00h. Bytes 40h–FFh read 000h and ignore writes.
- R8: Program-with-erase (code 001000) stores the latched word. Program-only (code 001010) stores the bitwise AND of the stored and latched values. Load-encoder (code 000011) latches the low 8 bits of the data word.
- R9: Bulk erase (code 001011) arms an erase. The next accepted program command, of either kind, sets every encoder byte to FFh in place of a word write, and it needs no prior load.
- R10: A program command is ignored unless a load or an armed bulk erase is pending. Each accepted word program uses up the pending load.
- R11: An accepted program command holds `busy` high for exactly PROG_CYCLES+1 clocks. Any program command received while `busy` is high is ignored, and so is the data loaded during that time.
- R12: Read-config (000100) and read-encoder (000101) give `rd_valid` high for one clock, starting on the clock after the command, with `rd_word` valid. Encoder data is zero-extended to 12 bits. Every other code gives no read and no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_enter | input | 1 | Program-mode entry pulse; outranks a command on the same clock |
| cmd_valid | input | 1 | A decoded command is present this clock |
| cmd_code | input | 6 | Command code |
| cmd_data | input | 12 | Data word carried by load commands |
| rd_valid | output | 1 | One-clock strobe: `rd_word` holds a read result |
| rd_word | output | 12 | Read result |
| busy | output | 1 | A program cycle is in progress |

## Verification
The bench targets the edges of the protect flag. It rewrites the shared word with the same flag and expects no change. A design that wrote it anyway would return 8A1h rather than 0A1h. It clears protection and expects every encoder byte to read FFh. Leaving out the bulk erase would give 00h. It sets protection again and expects an encoder read of zero even though the byte holds FFh.

Address handling is checked at the edges of the space. The counter wraps from 3FFh to 000h. The encoder byte space ends at 3Fh. PC 100h must alias byte 00h, and an unmasked counter would read 000h there. A write to 40h must change nothing.

The bench times the program cycle with a cycle counter. It checks that a second program command, and the data loaded during the cycle, leave the result of the cycle in progress untouched. It also checks that a program with no pending load starts no cycle, both after a mode entry and straight after reset.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int PC_W   = 10;
    localparam int CODE_W = 6;

    typedef enum logic [CODE_W-1:0] {
        OP_LD_CFG    = 6'b000000,
        OP_LD_ENC    = 6'b000011,
        OP_RD_CFG    = 6'b000100,
        OP_RD_ENC    = 6'b000101,
        OP_INC       = 6'b000110,
        OP_PGM_ERASE = 6'b001000,
        OP_PGM_ONLY  = 6'b001010,
        OP_BULK      = 6'b001011
    } opcode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

    typedef enum logic {
        TGT_CFG = 1'b0,
        TGT_ENC = 1'b1
    } target_e;

endpackage

// File: rtl/pce_prog_timer.sv
module pce_prog_timer #(
    parameter int CYCLES = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic running,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start && !run_q) begin
            cnt_q <= CW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign running = run_q;
    assign done    = run_q && (cnt_q == '0);

endmodule

// File: rtl/pce_enc_array.sv
module pce_enc_array #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill,
    input  logic                     wr_en,
    input  logic                     wr_and,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q[g] <= '0;
            end else if (fill) begin
                cell_q[g] <= '1;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                cell_q[g] <= wr_and ? (cell_q[g] & wr_data) : wr_data;
            end
        end
    end

    assign rd_data = cell_q[rd_idx];

endmodule

// File: rtl/pce_cfg_array.sv
module pce_cfg_array #(
    parameter int          RES_DEPTH = 8,
    parameter int          W         = 12,
    parameter logic [W-1:0] WORD_INIT = 12'h0A1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_and,
    input  logic                         wr_shared,
    input  logic [$clog2(RES_DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_shared,
    input  logic [$clog2(RES_DEPTH)-1:0] rd_idx,
    output logic [W-1:0]                 rd_data,
    output logic [W-1:0]                 word_q
);
    localparam int IW = $clog2(RES_DEPTH);

    logic [W-1:0] res_q [RES_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= WORD_INIT;
        end else if (wr_en && wr_shared) begin
            word_q <= wr_and ? (word_q & wr_data) : wr_data;
        end
    end

    for (genvar g = 0; g < RES_DEPTH; g++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (wr_en && !wr_shared && (wr_idx == IW'(g))) begin
                res_q[g] <= wr_and ? (res_q[g] & wr_data) : wr_data;
            end
        end
    end

    assign rd_data = rd_shared ? word_q : res_q[rd_idx];

endmodule

// File: rtl/pce_cmd_exec.sv
module pce_cmd_exec
    import pce_pkg::*;
#(
    parameter int              DATA_W      = 12,
    parameter int              ENC_W       = 8,
    parameter int              ENC_DEPTH   = 64,
    parameter int              ENC_AW      = 8,
    parameter int              CFG_RES     = 8,
    parameter int              PROT_BIT    = 6,
    parameter logic [DATA_W-1:0] CFG_INIT  = 12'h0A1,
    parameter int              PROG_CYCLES = 80000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_enter,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_code,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word,
    output logic              busy
);
    localparam int               EIW       = $clog2(ENC_DEPTH);
    localparam int               CRW       = $clog2(CFG_RES);
    localparam logic [ENC_AW-1:0] ENC_LIMIT = ENC_AW'(ENC_DEPTH);
    localparam logic [PC_W-1:0]  CFG_LIMIT = PC_W'(2 * CFG_RES);
    localparam logic [PC_W-1:0]  PC_ENTRY  = '1;

    state_e            state_q, state_d;
    logic [PC_W-1:0]   pc_q, addr_q;
    logic [DATA_W-1:0] latch_q, wdata_q;
    logic              latch_full_q, bulk_arm_q, and_mode_q, bulk_op_q;
    target_e           latch_tgt_q, tgt_q;

    // command decode
    logic live, is_ld_cfg, is_ld_enc, is_rd_cfg, is_rd_enc, is_inc, is_bulk, is_pgm, pgm_go;
    assign live      = cmd_valid && !mode_enter;
    assign is_ld_cfg = live && (cmd_code == OP_LD_CFG);
    assign is_ld_enc = live && (cmd_code == OP_LD_ENC);
    assign is_rd_cfg = live && (cmd_code == OP_RD_CFG);
    assign is_rd_enc = live && (cmd_code == OP_RD_ENC);
    assign is_inc    = live && (cmd_code == OP_INC);
    assign is_bulk   = live && (cmd_code == OP_BULK);
    assign is_pgm    = live && ((cmd_code == OP_PGM_ERASE) || (cmd_code == OP_PGM_ONLY));
    assign pgm_go    = is_pgm && (state_q == ST_IDLE) && (latch_full_q || bulk_arm_q);

    // program cycle timer
    logic tmr_running, tmr_done;
    pce_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (pgm_go),
        .running (tmr_running),
        .done    (tmr_done)
    );

    // memories
    logic [ENC_W-1:0]  enc_rd;
    logic [DATA_W-1:0] cfg_rd, cfg_word;
    logic              enc_we, enc_fill, cfg_we, unprotect, prot_n;
    logic              commit, a_enc_hit, a_cfg_hit, a_shared, cfg_flip;

    assign prot_n    = cfg_word[PROT_BIT];
    assign commit    = (state_q == ST_COMMIT);
    assign a_enc_hit = addr_q[ENC_AW-1:0] < ENC_LIMIT;
    assign a_cfg_hit = addr_q < CFG_LIMIT;
    assign a_shared  = addr_q[CRW];
    assign cfg_flip  = wdata_q[PROT_BIT] != cfg_word[PROT_BIT];

    assign enc_we    = commit && !bulk_op_q && (tgt_q == TGT_ENC) && a_enc_hit && prot_n;
    assign cfg_we    = commit && !bulk_op_q && (tgt_q == TGT_CFG) && a_cfg_hit
                       && (!a_shared || cfg_flip);
    assign unprotect = cfg_we && a_shared && !and_mode_q
                       && wdata_q[PROT_BIT] && !cfg_word[PROT_BIT];
    assign enc_fill  = (commit && bulk_op_q && prot_n) || unprotect;

    pce_enc_array #(.DEPTH(ENC_DEPTH), .W(ENC_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill    (enc_fill),
        .wr_en   (enc_we),
        .wr_and  (and_mode_q),
        .wr_idx  (addr_q[EIW-1:0]),
        .wr_data (wdata_q[ENC_W-1:0]),
        .rd_idx  (pc_q[EIW-1:0]),
        .rd_data (enc_rd)
    );

    pce_cfg_array #(.RES_DEPTH(CFG_RES), .W(DATA_W), .WORD_INIT(CFG_INIT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_and    (and_mode_q),
        .wr_shared (a_shared),
        .wr_idx    (addr_q[CRW-1:0]),
        .wr_data   (wdata_q),
        .rd_shared (pc_q[CRW]),
        .rd_idx    (pc_q[CRW-1:0]),
        .rd_data   (cfg_rd),
        .word_q    (cfg_word)
    );

    // state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pgm_go)   state_d = ST_BUSY;
            ST_BUSY:   if (tmr_done) state_d = ST_COMMIT;
            ST_COMMIT:               state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter, latch and captured program operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q         <= PC_ENTRY;
            latch_q      <= '0;
            latch_full_q <= 1'b0;
            latch_tgt_q  <= TGT_CFG;
            bulk_arm_q   <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            tgt_q        <= TGT_CFG;
            and_mode_q   <= 1'b0;
            bulk_op_q    <= 1'b0;
        end else if (mode_enter) begin
            pc_q         <= PC_ENTRY;
            latch_full_q <= 1'b0;
            bulk_arm_q   <= 1'b0;
        end else begin
            if (is_ld_cfg) begin
                latch_q      <= cmd_data;
                latch_full_q <= 1'b1;
                latch_tgt_q  <= TGT_CFG;
                pc_q         <= PC_ENTRY;
            end
            if (is_ld_enc) begin
                latch_q      <= {{(DATA_W-ENC_W){1'b0}}, cmd_data[ENC_W-1:0]};
                latch_full_q <= 1'b1;
                latch_tgt_q  <= TGT_ENC;
            end
            if (is_inc)  pc_q <= pc_q + 1'b1;
            if (is_bulk) bulk_arm_q <= 1'b1;
            if (pgm_go) begin
                addr_q     <= pc_q;
                wdata_q    <= latch_q;
                tgt_q      <= latch_tgt_q;
                and_mode_q <= (cmd_code == OP_PGM_ONLY);
                bulk_op_q  <= bulk_arm_q;
                if (bulk_arm_q) bulk_arm_q   <= 1'b0;
                else            latch_full_q <= 1'b0;
            end
        end
    end

    // read outputs
    logic [DATA_W-1:0] cfg_view, enc_view;
    assign cfg_view = (pc_q < CFG_LIMIT) ? cfg_rd : '0;
    assign enc_view = ((pc_q[ENC_AW-1:0] < ENC_LIMIT) && prot_n)
                      ? {{(DATA_W-ENC_W){1'b0}}, enc_rd} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= is_rd_cfg || is_rd_enc;
            if (is_rd_cfg)      rd_word <= cfg_view;
            else if (is_rd_enc) rd_word <= enc_view;
        end
    end

    assign busy = (state_q != ST_IDLE) || tmr_running;

endmodule

// File: rtl/pce_cmd_exec_chk.sv
module pce_cmd_exec_chk #(
    parameter int DATA_W = 12,
    parameter int PC_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_enter,
    input logic              cmd_valid,
    input logic [5:0]        cmd_code,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_word,
    input logic              busy,
    input logic [PC_W-1:0]   pc_q,
    input logic              prot_n
);
    // R1
    entry_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_enter |=> (pc_q == '1));

    // R2
    load_cfg_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mode_enter && cmd_code == 6'b000000) |=> (pc_q == '1));

    // R4
    protected_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mode_enter && cmd_code == 6'b000101 && !prot_n) |=> (rd_word == '0));

    // R12
    no_stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !mode_enter && (cmd_code == 6'b000100 || cmd_code == 6'b000101))
        |=> !rd_valid);

    // R12
    enc_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mode_enter && cmd_code == 6'b000101) |=> (rd_word[DATA_W-1:8] == '0));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && !mode_enter
                              && (cmd_code == 6'b001000 || cmd_code == 6'b001010)));

endmodule

bind pce_cmd_exec pce_cmd_exec_chk #(.DATA_W(DATA_W), .PC_W(pce_pkg::PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_enter (mode_enter),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .rd_valid   (rd_valid),
    .rd_word    (rd_word),
    .busy       (busy),
    .pc_q       (pc_q),
    .prot_n     (prot_n)
);

// File: tb/test_pce_cmd_exec.sv
module test_pce_cmd_exec;
    localparam int PROG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_enter = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_code = '0;
    logic [11:0] cmd_data = '0;
    logic        rd_valid;
    logic [11:0] rd_word;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    pce_cmd_exec #(.PROG_CYCLES(PROG)) i_pce_cmd_exec (
        .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .rd_valid(rd_valid),
        .rd_word(rd_word), .busy(busy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read result appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected read strobe", 16'd1, 16'd0);
            end else begin
                check(tag_q.pop_front(), 16'(rd_word), 16'(exp_q.pop_front()));
            end
        end
    end

    task automatic issue(input logic [5:0] code, input logic [11:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic enter();
        @(negedge clk);
        mode_enter = 1'b1;
        @(negedge clk);
        mode_enter = 1'b0;
    endtask

    task automatic rd(input logic [5:0] code, input logic [11:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(code, 12'h000);
    endtask

    task automatic incs(input int n);
        for (int i = 0; i < n; i++) issue(6'b000110, 12'h000);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", 16'(busy), 16'd0);
        check("R1 rd_valid after reset", 16'(rd_valid), 16'd0);
        rst_n = 1'b1;

        // R10 program with nothing pending, straight after reset
        issue(6'b001000, 12'h000);
        check("R10 program without load (reset)", 16'(busy), 16'd0);

        enter();
        rd(6'b000100, 12'h000, "R1 config read at entry address");
        issue(6'b001000, 12'h000);
        check("R10 program without load (entry)", 16'(busy), 16'd0);

        // R5: same protect bit, word must not change
        issue(6'b000000, 12'h8A1);
        incs(9);
        rd(6'b000100, 12'h0A1, "R2 R3 wrap to 000 then 008, reset word");
        issue(6'b001000, 12'h000);
        check("R11 busy after accepted program", 16'(busy), 16'd1);
        wait_idle();
        rd(6'b000100, 12'h0A1, "R5 unchanged protect bit blocks write");

        // R6: clear protection
        issue(6'b000000, 12'h0E1);
        incs(9);
        issue(6'b001000, 12'h000);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check("R11 busy length", 16'(n), 16'(PROG + 1));
        rd(6'b000100, 12'h0E1, "R5 protect bit change writes word");
        incs(7);
        rd(6'b000100, 12'h0E1, "R3 mirror at 00F");
        incs(1);
        rd(6'b000100, 12'h000, "R3 010 unimplemented");

        // reserved word write
        issue(6'b000000, 12'h123);
        incs(1);
        issue(6'b001000, 12'h000);
        wait_idle();
        rd(6'b000100, 12'h123, "R3 R8 reserved word 000 written");

        // encoder programming
        enter();
        incs(1);
        rd(6'b000101, 12'h0FF, "R6 encoder bulk erased on unprotect");
        issue(6'b000011, 12'hA3C);
        issue(6'b001000, 12'h000);
        wait_idle();
        rd(6'b000101, 12'h03C, "R8 erase+program stores low byte");
        issue(6'b000011, 12'h00F);
        issue(6'b001010, 12'h000);
        issue(6'b000011, 12'h000);
        issue(6'b001000, 12'h000);
        wait_idle();
        rd(6'b000101, 12'h00C, "R8 R11 program-only ANDs, busy program ignored");

        enter();
        incs(1);
        issue(6'b001000, 12'h000);
        check("R10 mode entry drops pending load", 16'(busy), 16'd0);

        incs(64);
        rd(6'b000101, 12'h000, "R7 byte 40 reads zero");
        issue(6'b000011, 12'h055);
        issue(6'b001000, 12'h000);
        wait_idle();
        rd(6'b000101, 12'h000, "R7 byte 40 ignores write");
        incs(192);
        rd(6'b000101, 12'h00C, "R7 PC 100 aliases byte 00");

        // R9 bulk erase via program-only without load
        issue(6'b001011, 12'h000);
        issue(6'b001010, 12'h000);
        check("R9 bulk erase starts cycle", 16'(busy), 16'd1);
        wait_idle();
        rd(6'b000101, 12'h0FF, "R9 bulk erase fills FF");

        // R12 unknown code
        issue(6'b111111, 12'hFFF);
        check("R12 unknown code no cycle", 16'(busy), 16'd0);

        // R4 protect again
        issue(6'b000000, 12'h0A1);
        incs(9);
        issue(6'b001000, 12'h000);
        wait_idle();
        rd(6'b000100, 12'h0A1, "R4 config readable while protected");
        enter();
        incs(1);
        rd(6'b000101, 12'h000, "R4 protected encoder reads zero");

        repeat (4) @(negedge clk);
        check("R12 all reads returned", 16'(exp_q.size()), 16'd0);
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule